// File: doc/BRIEF.md
# Programmable Parallel Port Controller

This block is a parallel I/O peripheral with three byte-wide ports, A, B and C, behind a small synchronous CPU bus. The bus has a chip select, a read strobe, a write strobe, a 2-bit address and separate 8-bit write and read data. A control word written through the bus sets the direction of each port group. It also puts ports A and B into either simple I/O or strobed handshake I/O. Each pad is modelled as three signals: a pin input, a driven value and an output enable.

In simple mode the output latches drive the pins and inputs are read straight from the pins. No interrupt is raised. Port C then works as two 4-bit ports with separate directions. In handshake mode, port A or port B, or both, latch data in both directions. Three port C lines per port are then taken over: one carries a strobe or acknowledge from the peripheral, one is a buffer-full flag and one is an interrupt request. The port C lines that the handshake does not use remain plain I/O. The interrupt enables are bits of the port C output latch and are set with a single-bit set/reset command.

The bus has no back-pressure. Every cycle with select and write high is one write, taken at that clock edge. Read data is combinational and appears in the same cycle that select and read are high. Outside a read the read data is zero.

Top module: `ppio_ctrl`

## Requirements
- R1: After reset, both ports are in simple mode and every port is an input. All output enables are low. A read of address 3 returns 0x9B.
- R2: Address 0 selects port A, 1 port B, 2 port C and 3 the control register. A control write with bit 7 set is a mode word. Its fields are: bit 6 = port A handshake, bit 4 = port A input, bit 3 = port C upper nibble input, bit 2 = port B handshake, bit 1 = port B input, bit 0 = port C lower nibble input. Bit 5 is ignored. Reading address 3 returns these fields with bit 7 = 1 and bit 5 = 0. The read data is 0 when no read is active.
- R3: In simple mode, a read of an input port returns the live pin value in the same cycle.
- R4: In simple mode, a write to an output port is latched. The latch drives the port output, all enable bits of that port are high, and a read returns the latch.
- R5: In simple mode, the two nibbles of port C have their own directions. A port C read returns the pins for input bits and the latch for output bits.
- R6: A control write with bit 7 clear changes only the port C latch bit numbered by bits 3:1, setting it to bit 0. The mode is left unchanged.
- R7: A mode word clears the A, B and C output latches, the buffer-full flags and the interrupts.
- R8: In simple mode no interrupt is raised. Port C lines 3 and 5 keep showing their latch bits while line 4 toggles.
- R9: In handshake input mode, a low strobe (port A: C4, port B: C2) latches the pins and sets buffer-full, which is active high (A: C5, B: C1). The strobe's rising edge sets the interrupt (A: C3, B: C0) when the enable is set (A: latch bit 4, B: latch bit 2). A port read returns the latched byte and clears the interrupt. Buffer-full clears in the cycle after the read ends.
- R10: In handshake output mode, a port write latches the data, drives the buffer-full line low and clears the interrupt. A low acknowledge (same line as the strobe) drives the buffer-full line high. The acknowledge's rising edge sets the interrupt when enabled.
- R11: With the enable bit clear, the handshake flags still operate but the interrupt stays low.
- R12: Port C lines not used by a handshake stay simple I/O and follow their nibble's direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| addr | input | 2 | Register select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A driven values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B driven values |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C driven values |
| pc_oe | output | 8 | Port C output enables |

## Verification
The bench changes an input pin between two reads with no strobe. A design that latched simple-mode inputs would return stale data, and one that did not latch handshake data would return the new pin value instead of the strobed byte. Buffer-full is checked both while the read is still active and one cycle after it ends, which catches a flag cleared too early or never cleared. The bench repeats the strobe and acknowledge sequences with the enable bit clear and in simple mode, so a design that raises an interrupt regardless of the enable or the mode shows up as a wrong port C line. It also writes a mode word with the ignored bit set and a bit set/reset word, which exposes decoders that mix the two formats.

// File: rtl/ppio_pkg.sv
package ppio_pkg;
  // port C lines taken by the handshakes
  localparam int A_IRQ_BIT = 3;
  localparam int A_STB_BIT = 4;
  localparam int A_BF_BIT  = 5;
  localparam int B_IRQ_BIT = 0;
  localparam int B_BF_BIT  = 1;
  localparam int B_STB_BIT = 2;

  typedef enum logic [1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CTL = 2'd3
  } ppio_sel_e;

  typedef struct packed {
    logic a_hs;
    logic a_in;
    logic cu_in;
    logic b_hs;
    logic b_in;
    logic cl_in;
  } ppio_cfg_t;

  localparam ppio_cfg_t CFG_RESET = '{a_hs: 1'b0, a_in: 1'b1, cu_in: 1'b1,
                                      b_hs: 1'b0, b_in: 1'b1, cl_in: 1'b1};
endpackage

// File: rtl/ppio_cfg.sv
module ppio_cfg
  import ppio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic          pc_wr,
  input  logic [DW-1:0] wdata,
  output ppio_cfg_t     cfg,
  output logic [DW-1:0] pc_latch,
  output logic          mode_load
);
  localparam int BW = $clog2(DW);

  assign mode_load = ctl_wr & wdata[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg      <= CFG_RESET;
      pc_latch <= '0;
    end else if (mode_load) begin
      cfg.a_hs  <= wdata[6];
      cfg.a_in  <= wdata[4];
      cfg.cu_in <= wdata[3];
      cfg.b_hs  <= wdata[2];
      cfg.b_in  <= wdata[1];
      cfg.cl_in <= wdata[0];
      pc_latch  <= '0;
    end else if (ctl_wr) begin
      pc_latch[wdata[BW:1]] <= wdata[0];
    end else if (pc_wr) begin
      pc_latch <= wdata;
    end
  end
endmodule

// File: rtl/ppio_hs_port.sv
module ppio_hs_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          hs_en,
  input  logic          is_in,
  input  logic          inte,
  input  logic          stb_n,
  input  logic [DW-1:0] pins,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] out_q,
  output logic [DW-1:0] in_q,
  output logic          irq,
  output logic          bf
);
  logic stb_prev, rd_prev;
  logic rise, rd_end;

  assign rise   = ~stb_prev & stb_n;
  assign rd_end = rd_prev & ~cpu_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_prev <= 1'b1;
      rd_prev  <= 1'b0;
      out_q    <= '0;
      in_q     <= '0;
      irq      <= 1'b0;
      bf       <= 1'b0;
    end else begin
      stb_prev <= stb_n;
      rd_prev  <= cpu_rd;
      if (clr) begin
        out_q <= '0;
        in_q  <= '0;
        irq   <= 1'b0;
        bf    <= 1'b0;
      end else begin
        if (cpu_wr) out_q <= wdata;
        if (!hs_en) begin
          irq <= 1'b0;
          bf  <= 1'b0;
        end else if (is_in) begin
          if (!stb_n) begin
            in_q <= pins;
            bf   <= 1'b1;
          end else if (rd_end) begin
            bf <= 1'b0;
          end
          if (rise && inte)  irq <= 1'b1;
          else if (cpu_rd)   irq <= 1'b0;
        end else begin
          if (cpu_wr)        bf <= 1'b1;
          else if (!stb_n)   bf <= 1'b0;
          if (cpu_wr)              irq <= 1'b0;
          else if (rise && inte)   irq <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ppio_pc_map.sv
module ppio_pc_map
  import ppio_pkg::*;
#(
  parameter int DW = 8
) (
  input  ppio_cfg_t     cfg,
  input  logic [DW-1:0] pc_latch,
  input  logic [DW-1:0] pc_in,
  input  logic [1:0]    irq,
  input  logic [1:0]    bf,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pc_oe,
  output logic [DW-1:0] pc_rd
);
  localparam int HALF = DW / 2;

  always_comb begin
    for (int i = 0; i < DW; i++) begin
      pc_oe[i]  = (i < HALF) ? ~cfg.cl_in : ~cfg.cu_in;
      pc_out[i] = pc_latch[i];
      pc_rd[i]  = pc_oe[i] ? pc_latch[i] : pc_in[i];
    end
    if (cfg.a_hs) begin
      pc_out[A_IRQ_BIT] = irq[0];
      pc_oe[A_IRQ_BIT]  = 1'b1;
      pc_rd[A_IRQ_BIT]  = irq[0];
      pc_out[A_BF_BIT]  = cfg.a_in ? bf[0] : ~bf[0];
      pc_oe[A_BF_BIT]   = 1'b1;
      pc_rd[A_BF_BIT]   = cfg.a_in ? bf[0] : ~bf[0];
      pc_oe[A_STB_BIT]  = 1'b0;
      pc_rd[A_STB_BIT]  = pc_latch[A_STB_BIT];
    end
    if (cfg.b_hs) begin
      pc_out[B_IRQ_BIT] = irq[1];
      pc_oe[B_IRQ_BIT]  = 1'b1;
      pc_rd[B_IRQ_BIT]  = irq[1];
      pc_out[B_BF_BIT]  = cfg.b_in ? bf[1] : ~bf[1];
      pc_oe[B_BF_BIT]   = 1'b1;
      pc_rd[B_BF_BIT]   = cfg.b_in ? bf[1] : ~bf[1];
      pc_oe[B_STB_BIT]  = 1'b0;
      pc_rd[B_STB_BIT]  = pc_latch[B_STB_BIT];
    end
  end
endmodule

// File: rtl/ppio_ctrl.sv
module ppio_ctrl
  import ppio_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          rd,
  input  logic          wr,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic [DW-1:0] pc_in,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] pc_oe
);
  localparam int NP = 2;

  ppio_sel_e     sel;
  logic          acc_wr, acc_rd;
  ppio_cfg_t     cfg;
  logic [DW-1:0] pc_latch, pc_rd;
  logic          mode_load;

  logic [DW-1:0] port_pins [NP];
  logic [DW-1:0] out_q     [NP];
  logic [DW-1:0] in_q      [NP];
  logic [DW-1:0] port_rd   [NP];
  logic [NP-1:0] hs_en, is_in, inte, stb_n, cpu_wr, cpu_rd, irq, bf;
  logic [DW-1:0] ctl_rd;

  assign sel    = ppio_sel_e'(addr);
  assign acc_wr = cs & wr;
  assign acc_rd = cs & rd;

  ppio_cfg #(.DW(DW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl_wr   (acc_wr && sel == SEL_CTL),
    .pc_wr    (acc_wr && sel == SEL_C),
    .wdata    (wdata),
    .cfg      (cfg),
    .pc_latch (pc_latch),
    .mode_load(mode_load)
  );

  assign port_pins[0] = pa_in;
  assign port_pins[1] = pb_in;
  assign hs_en  = {cfg.b_hs, cfg.a_hs};
  assign is_in  = {cfg.b_in, cfg.a_in};
  assign inte   = {pc_latch[B_STB_BIT], pc_latch[A_STB_BIT]};
  assign stb_n  = {pc_in[B_STB_BIT], pc_in[A_STB_BIT]};
  assign cpu_wr = {acc_wr && sel == SEL_B, acc_wr && sel == SEL_A};
  assign cpu_rd = {acc_rd && sel == SEL_B, acc_rd && sel == SEL_A};

  for (genvar g = 0; g < NP; g++) begin : g_port
    ppio_hs_port #(.DW(DW)) u_hs (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (mode_load),
      .hs_en (hs_en[g]),
      .is_in (is_in[g]),
      .inte  (inte[g]),
      .stb_n (stb_n[g]),
      .pins  (port_pins[g]),
      .cpu_wr(cpu_wr[g]),
      .cpu_rd(cpu_rd[g]),
      .wdata (wdata),
      .out_q (out_q[g]),
      .in_q  (in_q[g]),
      .irq   (irq[g]),
      .bf    (bf[g])
    );
    assign port_rd[g] = !is_in[g] ? out_q[g] : (hs_en[g] ? in_q[g] : port_pins[g]);
  end

  ppio_pc_map #(.DW(DW)) u_pc (
    .cfg     (cfg),
    .pc_latch(pc_latch),
    .pc_in   (pc_in),
    .irq     (irq),
    .bf      (bf),
    .pc_out  (pc_out),
    .pc_oe   (pc_oe),
    .pc_rd   (pc_rd)
  );

  assign pa_out = out_q[0];
  assign pb_out = out_q[1];
  assign pa_oe  = {DW{~cfg.a_in}};
  assign pb_oe  = {DW{~cfg.b_in}};

  always_comb begin
    ctl_rd      = '0;
    ctl_rd[7:0] = {1'b1, cfg.a_hs, 1'b0, cfg.a_in, cfg.cu_in, cfg.b_hs, cfg.b_in, cfg.cl_in};
  end

  always_comb begin
    rdata = '0;
    if (acc_rd) begin
      case (sel)
        SEL_A:   rdata = port_rd[0];
        SEL_B:   rdata = port_rd[1];
        SEL_C:   rdata = pc_rd;
        default: rdata = ctl_rd;
      endcase
    end
  end
endmodule

// File: rtl/ppio_ctrl_chk.sv
module ppio_ctrl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          wr,
  input logic [1:0]    addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] pa_out,
  input logic [DW-1:0] pb_out,
  input logic [DW-1:0] pa_oe,
  input logic [DW-1:0] pc_in,
  input logic [DW-1:0] pc_out,
  input logic [DW-1:0] pc_latch,
  input logic          a_hs,
  input logic          a_in,
  input logic          b_hs,
  input logic [1:0]    irq
);
  logic mode_wr, bit_wr;
  assign mode_wr = cs && wr && addr == 2'd3 && wdata[7];
  assign bit_wr  = cs && wr && addr == 2'd3 && !wdata[7];

  p_mode_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> (pa_out == '0 && pb_out == '0 && irq == 2'b00));

  p_obf_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (a_hs && !a_in && cs && wr && addr == 2'd0) |=> !pc_out[5]);

  p_ibf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (a_hs && a_in && !pc_in[4] && !mode_wr) |=> pc_out[5]);

  p_no_irq_simple_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!a_hs |-> !irq[0]) and (!b_hs |-> !irq[1]));

  p_bitset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_wr |=> pc_latch[$past(wdata[3:1])] == $past(wdata[0]));

  p_oe_uniform_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_oe == '0) || (pa_oe == '1));
endmodule

bind ppio_ctrl ppio_ctrl_chk #(.DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs      (cs),
  .wr      (wr),
  .addr    (addr),
  .wdata   (wdata),
  .pa_out  (pa_out),
  .pb_out  (pb_out),
  .pa_oe   (pa_oe),
  .pc_in   (pc_in),
  .pc_out  (pc_out),
  .pc_latch(pc_latch),
  .a_hs    (cfg.a_hs),
  .a_in    (cfg.a_in),
  .b_hs    (cfg.b_hs),
  .irq     (irq)
);

// File: tb/sim_ppio_ctrl.sv
module sim_ppio_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'hFF;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  int vec = 0, mis = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ppio_ctrl #(.DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    vec++;
    if (act !== exp) begin
      mis++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 pa_oe", pa_oe, 8'h00);
    check("R1 pb_oe", pb_oe, 8'h00);
    check("R1 pc_oe", pc_oe, 8'h00);
    bus_rd(2'd3, d);
    check("R1 ctl", d, 8'h9B);
  endtask

  task automatic t_ctl_map;
    logic [7:0] d;
    bus_wr(2'd3, 8'hF6);
    bus_rd(2'd3, d);
    check("R2 ctl readback bit5 ignored", d, 8'hD6);
    #1 check("R2 idle rdata", rdata, 8'h00);
    bus_wr(2'd3, 8'h9B);
  endtask

  task automatic t_simple_in;
    logic [7:0] d;
    pa_in = 8'h5A;
    bus_rd(2'd0, d);
    check("R3 live A", d, 8'h5A);
    pa_in = 8'hC3;
    bus_rd(2'd0, d);
    check("R3 live A changed", d, 8'hC3);
  endtask

  task automatic t_simple_out;
    logic [7:0] d;
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd0, 8'h3C);
    check("R4 pa_out", pa_out, 8'h3C);
    check("R4 pa_oe", pa_oe, 8'hFF);
    pa_in = 8'h00;
    bus_rd(2'd0, d);
    check("R4 A readback latch", d, 8'h3C);
  endtask

  task automatic t_c_nibbles;
    logic [7:0] d;
    bus_wr(2'd3, 8'h88);
    check("R5 pc_oe", pc_oe, 8'h0F);
    bus_wr(2'd2, 8'hA5);
    check("R5 pc_out low", pc_out & 8'h0F, 8'h05);
    pc_in = 8'h7F;
    bus_rd(2'd2, d);
    check("R5 C read mix", d, 8'h75);
    pc_in = 8'hFF;
  endtask

  task automatic t_bitset;
    logic [7:0] d;
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd3, 8'h0D);
    check("R6 set bit6", pc_out, 8'h40);
    bus_wr(2'd3, 8'h03);
    check("R6 set bit1", pc_out, 8'h42);
    bus_wr(2'd3, 8'h0C);
    check("R6 clear bit6", pc_out, 8'h02);
    bus_rd(2'd3, d);
    check("R6 mode kept", d, 8'h80);
  endtask

  task automatic t_mode_clear;
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd0, 8'hFF);
    bus_wr(2'd1, 8'hAA);
    bus_wr(2'd2, 8'hFF);
    bus_wr(2'd3, 8'h80);
    check("R7 pa_out cleared", pa_out, 8'h00);
    check("R7 pb_out cleared", pb_out, 8'h00);
    check("R7 pc_out cleared", pc_out, 8'h00);
  endtask

  task automatic t_simple_noirq;
    bus_wr(2'd3, 8'h80);
    bus_wr(2'd3, 8'h09);
    @(negedge clk) pc_in[4] = 1'b0;
    @(negedge clk) pc_in[4] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R8 no irq in simple mode", pc_out, 8'h10);
  endtask

  task automatic t_hs_in_a;
    logic [7:0] d;
    bus_wr(2'd3, 8'hD0);
    bus_wr(2'd3, 8'h09);
    check("R9 idle bf", pc_out[5], 1'b0);
    pa_in = 8'h77;
    @(negedge clk) pc_in[4] = 1'b0;
    @(negedge clk) begin pc_in[4] = 1'b1; pa_in = 8'h11; end
    check("R9 bf after strobe", pc_out[5], 1'b1);
    check("R9 no irq before rise", pc_out[3], 1'b0);
    @(negedge clk);
    check("R9 irq after rise", pc_out[3], 1'b1);
    bus_rd(2'd0, d);
    check("R9 latched data", d, 8'h77);
    check("R9 irq cleared by read", pc_out[3], 1'b0);
    check("R9 bf held until read ends", pc_out[5], 1'b1);
    @(negedge clk);
    check("R9 bf cleared", pc_out[5], 1'b0);
  endtask

  task automatic t_free_c;
    bus_wr(2'd3, 8'hD0);
    check("R12 pc_oe map", pc_oe, 8'hEF);
    bus_wr(2'd3, 8'h0F);
    check("R12 free bit7 drives", pc_out[7], 1'b1);
    bus_wr(2'd3, 8'hD8);
    check("R12 upper input", pc_oe, 8'h2F);
  endtask

  task automatic t_hs_out_b;
    bus_wr(2'd3, 8'h84);
    bus_wr(2'd3, 8'h05);
    check("R10 obf idle high", pc_out[1], 1'b1);
    bus_wr(2'd1, 8'h9E);
    check("R10 pb_out", pb_out, 8'h9E);
    check("R10 obf low", pc_out[1], 1'b0);
    check("R10 irq low", pc_out[0], 1'b0);
    @(negedge clk) pc_in[2] = 1'b0;
    @(negedge clk) pc_in[2] = 1'b1;
    check("R10 ack frees buffer", pc_out[1], 1'b1);
    @(negedge clk);
    check("R10 irq on ack rise", pc_out[0], 1'b1);
    bus_wr(2'd1, 8'h01);
    check("R10 write clears irq", pc_out[0], 1'b0);
    check("R10 write sets obf", pc_out[1], 1'b0);
  endtask

  task automatic t_inte_off;
    logic [7:0] d;
    bus_wr(2'd3, 8'h86);
    pb_in = 8'h42;
    @(negedge clk) pc_in[2] = 1'b0;
    @(negedge clk) begin pc_in[2] = 1'b1; pb_in = 8'h00; end
    @(negedge clk);
    check("R11 bf set", pc_out[1], 1'b1);
    check("R11 irq stays low", pc_out[0], 1'b0);
    bus_rd(2'd1, d);
    check("R11 data", d, 8'h42);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctl_map();
    t_simple_in();
    t_simple_out();
    t_c_nibbles();
    t_bitset();
    t_mode_clear();
    t_simple_noirq();
    t_hs_in_a();
    t_free_c();
    t_hs_out_b();
    t_inte_off();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      vec++;
      mis++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vec, mis);
      $finish;
    end
  end
endmodule